// File: doc/BRIEF.md
# Nested task link controller

This block keeps the bookkeeping that a small protected-mode style processor model needs for nested task switches. It holds the task register (the selector of the task now running), the nested-task flag, one busy bit per task descriptor, and for every task a back-link selector and a saved copy of the nested-task flag. The rest of the processor model raises one-cycle requests and reads back the new current selector. There are two kinds of request. A call-type switch can come through a call gate, a task gate, a hardware interrupt or exception, or a software interrupt. A return can be an interrupt return or a plain return.

A call-type switch to an idle task records the outgoing selector in the called task's back-link. It marks the called task busy and sets the nested-task flag, so the chain of suspended tasks is kept in the descriptors themselves and not on a stack. An interrupt return with the flag set follows the back-link of the current task. It frees the outgoing task and reloads the flag from the resumed task's saved copy. A call to a task that is already busy does not switch; it raises a one-cycle general-protection fault strobe. Saving registers, fetching descriptors and checking privileges are left to other blocks.

Top module: `nested_task_link`

## Requirements
- R1: After reset, curSel is 0, busyVec has only bit 0 set, ntFlag is 0, and switchDone and gpFault are both 0.
- R2: A callReq to a target whose busy bit is 0 has these effects in the cycle after the request: curSel equals the target, the target's busy bit is 1, ntFlag is 1, and switchDone is high for exactly that one cycle.
- R3: The back-link of a called task holds the selector that was current when it was called, so a later accepted iretReq from that task makes curSel equal to that selector.
- R4: A callReq to a target whose busy bit is 1 (this includes the current task itself) leaves curSel, ntFlag and busyVec unchanged. It does not raise switchDone. It raises gpFault for exactly the cycle after the request.
- R5: An iretReq while ntFlag is 1 has these effects in the next cycle: it clears the busy bit of the outgoing task, sets curSel to that task's back-link, and pulses switchDone. It does not raise gpFault, even though the resumed task is busy.
- R6: After an accepted iretReq, ntFlag equals the value it had when the resumed task was switched away from: 0 when task 0 is resumed, 1 for any task that was itself called.
- R7: A retReq on its own never changes curSel, ntFlag or busyVec, and never raises switchDone, whatever the value of ntFlag.
- R8: An iretReq while ntFlag is 0 changes no state and raises neither strobe.
- R9: The callKind code (0 call gate, 1 task gate, 2 hardware interrupt or exception, 3 software interrupt) has no effect on the result of a call-type switch.
- R10: Calls can nest until every task is busy. After chained calls 0→a→b, busyVec has bits 0, a and b set, and returns unwind in reverse order.
- R11: Any request presented in a cycle in which gpFault is high is ignored: no state changes and neither strobe is raised.
- R12: When more than one request is high in the same cycle, callReq wins over iretReq, and iretReq wins over retReq; the losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| callReq | input | 1 | One-cycle call-type task switch request |
| callKind | input | 2 | Source of the call-type switch (no effect on behaviour) |
| callTarget | input | SEL_W | Selector (task index) of the called task |
| iretReq | input | 1 | One-cycle interrupt-return request |
| retReq | input | 1 | One-cycle plain-return request |
| curSel | output | SEL_W | Task register: selector of the current task |
| ntFlag | output | 1 | Nested-task flag |
| busyVec | output | NUM_TASKS | Busy bit of each task descriptor |
| switchDone | output | 1 | Pulses in the cycle after a completed task switch |
| gpFault | output | 1 | Pulses in the cycle after a call to a busy task |

## Verification
The bench drives fixed sequences and then a long stretch of random requests. The fixed sequences cover a deep call chain that fills every task, unwinding by interrupt returns, calls to the current task and to suspended tasks, plain returns in the middle of a chain, and interrupt returns at the outermost level. The chain and unwind show whether back-links and saved flags are recorded against the right task. The busy-target and self calls separate a faulting call from an accepted one. Plain and outermost returns show that returns are gated on the flag and on the request type. Simultaneous requests and requests made while the fault strobe is high check the priority and the lockout. The random stretch, with all four call kinds, compares every output on every clock against a chain-queue model.

// File: rtl/ntl_pkg.sv
`timescale 1ns/1ps
package ntl_pkg;

  // decoded request after priority resolution
  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_CALL = 2'd1,
    REQ_IRET = 2'd2,
    REQ_RET  = 2'd3
  } reqKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic doCall;    // accepted call-type switch
    logic doReturn;  // accepted nested return
  } ntlStrobe_t;

endpackage

// File: rtl/ntl_ctrl.sv
`timescale 1ns/1ps
module ntl_ctrl
  import ntl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       callReq,
  input  logic [1:0] callKind,
  input  logic       iretReq,
  input  logic       retReq,
  input  logic       targetBusy,
  input  logic       ntFlag,
  output ntlStrobe_t strobe,
  output logic       switchDone,
  output logic       gpFault
);

  reqKind_e reqKind;
  logic     callIsSwitch;
  logic     accept;
  logic     raiseFault;

  // every call source resolves to the same linking switch
  always_comb begin
    case (callKind)
      2'd0:    callIsSwitch = 1'b1;  // call gate
      2'd1:    callIsSwitch = 1'b1;  // task gate
      2'd2:    callIsSwitch = 1'b1;  // hardware interrupt / exception
      default: callIsSwitch = 1'b1;  // software interrupt
    endcase
  end

  // fixed priority: call, then iret, then ret
  always_comb begin
    if (callReq)      reqKind = REQ_CALL;
    else if (iretReq) reqKind = REQ_IRET;
    else if (retReq)  reqKind = REQ_RET;
    else              reqKind = REQ_NONE;
  end

  // the cycle carrying a fault strobe accepts nothing
  assign accept = !gpFault;

  always_comb begin
    strobe          = '0;
    raiseFault      = 1'b0;
    if (accept) begin
      unique case (reqKind)
        REQ_CALL: begin
          if (callIsSwitch && !targetBusy) strobe.doCall = 1'b1;
          else                             raiseFault    = 1'b1;
        end
        REQ_IRET: strobe.doReturn = ntFlag;
        REQ_RET:  strobe.doReturn = 1'b0;  // never a task switch
        default:  strobe.doReturn = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      switchDone <= 1'b0;
      gpFault    <= 1'b0;
    end else begin
      switchDone <= strobe.doCall | strobe.doReturn;
      gpFault    <= raiseFault;
    end
  end

endmodule

// File: rtl/ntl_datapath.sv
`timescale 1ns/1ps
module ntl_datapath
  import ntl_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  localparam int SEL_W    = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ntlStrobe_t           strobe,
  input  logic [SEL_W-1:0]     callTarget,
  output logic [SEL_W-1:0]     curSel,
  output logic                 ntFlag,
  output logic [NUM_TASKS-1:0] busyVec,
  output logic                 targetBusy
);

  logic [SEL_W-1:0] linkTab  [NUM_TASKS];
  logic [NUM_TASKS-1:0] savedNt;
  logic [SEL_W-1:0] backSel;

  assign targetBusy = busyVec[callTarget];
  assign backSel    = linkTab[curSel];

  // per-task descriptor state: busy bit, back-link, saved flag
  for (genvar g = 0; g < NUM_TASKS; g++) begin : gSlot
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);
    logic             busyQ;
    logic [SEL_W-1:0] linkQ;
    logic             ntQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busyQ <= (g == 0);
        linkQ <= '0;
        ntQ   <= 1'b0;
      end else begin
        if (strobe.doCall && callTarget == MY_SEL) begin
          busyQ <= 1'b1;
          linkQ <= curSel;
        end
        if (strobe.doCall && curSel == MY_SEL) ntQ <= ntFlag;
        if (strobe.doReturn && curSel == MY_SEL) busyQ <= 1'b0;
      end
    end

    assign busyVec[g] = busyQ;
    assign linkTab[g] = linkQ;
    assign savedNt[g] = ntQ;
  end

  // task register and nested-task flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSel <= '0;
      ntFlag <= 1'b0;
    end else if (strobe.doCall) begin
      curSel <= callTarget;
      ntFlag <= 1'b1;
    end else if (strobe.doReturn) begin
      curSel <= backSel;
      ntFlag <= savedNt[backSel];
    end
  end

endmodule

// File: rtl/nested_task_link.sv
`timescale 1ns/1ps
module nested_task_link
  import ntl_pkg::*;
#(
  parameter int NUM_TASKS = 8,
  localparam int SEL_W    = $clog2(NUM_TASKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 callReq,
  input  logic [1:0]           callKind,
  input  logic [SEL_W-1:0]     callTarget,
  input  logic                 iretReq,
  input  logic                 retReq,
  output logic [SEL_W-1:0]     curSel,
  output logic                 ntFlag,
  output logic [NUM_TASKS-1:0] busyVec,
  output logic                 switchDone,
  output logic                 gpFault
);

  ntlStrobe_t strobe;
  logic       targetBusy;

  ntl_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .callReq    (callReq),
    .callKind   (callKind),
    .iretReq    (iretReq),
    .retReq     (retReq),
    .targetBusy (targetBusy),
    .ntFlag     (ntFlag),
    .strobe     (strobe),
    .switchDone (switchDone),
    .gpFault    (gpFault)
  );

  ntl_datapath #(.NUM_TASKS(NUM_TASKS)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .callTarget (callTarget),
    .curSel     (curSel),
    .ntFlag     (ntFlag),
    .busyVec    (busyVec),
    .targetBusy (targetBusy)
  );

endmodule

// File: rtl/ntl_chk.sv
`timescale 1ns/1ps
module ntl_chk #(
  parameter int NUM_TASKS = 8,
  localparam int SEL_W    = $clog2(NUM_TASKS)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 callReq,
  input logic [SEL_W-1:0]     callTarget,
  input logic                 iretReq,
  input logic                 retReq,
  input logic [SEL_W-1:0]     curSel,
  input logic                 ntFlag,
  input logic [NUM_TASKS-1:0] busyVec,
  input logic                 switchDone,
  input logic                 gpFault
);

  // R1
  outer_task_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyVec[0]);

  // R2
  call_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && !gpFault && !busyVec[callTarget])
      |=> (curSel == $past(callTarget)) && ntFlag && switchDone
          && busyVec[$past(callTarget)]);

  // R4
  busy_call_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && !gpFault && busyVec[callTarget])
      |=> gpFault && !switchDone && $stable(curSel) && $stable(busyVec)
          && $stable(ntFlag));

  // R4
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gpFault && switchDone));

  // R5
  iret_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iretReq && !callReq && ntFlag && !gpFault)
      |=> switchDone && !gpFault && !busyVec[$past(curSel)]);

  // R7
  ret_no_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !callReq && !iretReq)
      |=> !switchDone && $stable(curSel) && $stable(busyVec) && $stable(ntFlag));

  // R8
  iret_flat_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iretReq && !callReq && !ntFlag)
      |=> !switchDone && !gpFault && $stable(curSel) && $stable(busyVec));

  // R11
  fault_lockout_chk: assert property (@(posedge clk) disable iff (!rstN)
    gpFault |=> !switchDone && !gpFault && $stable(curSel) && $stable(busyVec)
                && $stable(ntFlag));

endmodule

bind nested_task_link ntl_chk #(.NUM_TASKS(NUM_TASKS)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .callReq    (callReq),
  .callTarget (callTarget),
  .iretReq    (iretReq),
  .retReq     (retReq),
  .curSel     (curSel),
  .ntFlag     (ntFlag),
  .busyVec    (busyVec),
  .switchDone (switchDone),
  .gpFault    (gpFault)
);

// File: tb/tb_nested_task_link.sv
`timescale 1ns/1ps
module tb_nested_task_link;

  localparam int N = 8;
  localparam int W = $clog2(N);

  logic         clk = 1'b0;
  logic         rstN;
  logic         callReq, iretReq, retReq;
  logic [1:0]   callKind;
  logic [W-1:0] callTarget;
  logic [W-1:0] curSel;
  logic         ntFlag, switchDone, gpFault;
  logic [N-1:0] busyVec;

  int vectors = 0;
  int misses  = 0;

  // reference model: chain of active tasks, outermost first
  int chain[$];
  bit expSd, expGp;

  always #4 clk = ~clk;  // 125 MHz

  nested_task_link #(.NUM_TASKS(N)) dut (
    .clk(clk), .rstN(rstN), .callReq(callReq), .callKind(callKind),
    .callTarget(callTarget), .iretReq(iretReq), .retReq(retReq),
    .curSel(curSel), .ntFlag(ntFlag), .busyVec(busyVec),
    .switchDone(switchDone), .gpFault(gpFault));

  function automatic bit inChain(int t);
    foreach (chain[i]) if (chain[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [N-1:0] expBusy();
    logic [N-1:0] b = '0;
    foreach (chain[i]) b[chain[i]] = 1'b1;
    return b;
  endfunction

  task automatic modelStep(bit c, int t, bit i);
    bit nSd = 0, nGp = 0;
    if (!expGp) begin
      if (c) begin
        if (inChain(t)) nGp = 1;
        else begin chain.push_back(t); nSd = 1; end
      end else if (i && chain.size() > 1) begin
        void'(chain.pop_back());
        nSd = 1;
      end
    end
    expSd = nSd;
    expGp = nGp;
  endtask

  task automatic compare(string tag);
    logic [W-1:0] eSel = W'(chain[$]);
    logic         eNt  = (chain.size() > 1);
    vectors++;
    if (curSel !== eSel || ntFlag !== eNt || busyVec !== expBusy()
        || switchDone !== expSd || gpFault !== expGp) begin
      misses++;
      $display("FAIL %s: sel=%0d nt=%0b busy=%b sd=%0b gp=%0b, expected sel=%0d nt=%0b busy=%b sd=%0b gp=%0b",
               tag, curSel, ntFlag, busyVec, switchDone, gpFault,
               eSel, eNt, expBusy(), expSd, expGp);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit c, int k, int t, bit i, bit r, string tag);
    callReq = c; callKind = 2'(k); callTarget = W'(t);
    iretReq = i; retReq = r;
    @(posedge clk);
    modelStep(c, t, i);
    @(negedge clk);
    compare(tag);
    callReq = 0; iretReq = 0; retReq = 0;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 150000);
    misses++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rstN = 0; callReq = 0; iretReq = 0; retReq = 0; callKind = 0; callTarget = 0;
    chain.push_back(0); expSd = 0; expGp = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    compare("R1 reset");
    idle("R1 idle");

    step(1, 0, 3, 0, 0, "R2 call 0->3");
    step(1, 2, 5, 0, 0, "R9 hw-int 3->5");
    step(1, 1, 3, 0, 0, "R4 call busy 3");
    step(1, 3, 6, 0, 0, "R11 request during fault");
    step(0, 0, 0, 0, 1, "R7 ret nested");
    step(0, 0, 0, 1, 0, "R3 iret 5->3");
    step(0, 0, 0, 1, 0, "R6 iret 3->0 nt cleared");
    step(0, 0, 0, 1, 0, "R8 iret nt=0");
    step(0, 0, 0, 0, 1, "R7 ret outermost");
    step(1, 0, 0, 0, 0, "R4 call self");
    idle("R11 fault cleared");

    for (int t = 1; t < N; t++) step(1, t % 4, t, 0, 0, "R10 chain build");
    step(1, 1, 2, 0, 0, "R4 call suspended");
    idle("R4 idle");
    step(0, 0, 0, 1, 1, "R12 iret over ret");
    step(1, 0, 7, 1, 0, "R12 call over iret");
    idle("R12 idle");
    for (int t = 0; t < N; t++) step(0, 0, 0, 1, 0, "R5 unwind");

    step(1, 3, 4, 1, 1, "R12 call wins");
    step(0, 0, 0, 1, 0, "R5 iret back");

    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 9);
      step(sel < 4, $urandom_range(0, 3), $urandom_range(0, N - 1),
           sel inside {4, 5, 6, 9}, sel inside {7, 9}, "R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule